// File: doc/BRIEF.md
# Daisy-Chained Serial DAC Frame Controller

This block sits on the host side of a chain of serial DAC devices that share one serial clock and one active-low select/load line. Each device's data output feeds the next device's data input, so the whole chain acts as one long shift register. The user hands over one 16-bit command word per device through a valid/ready stream. Once a full set of `NDEV` words has arrived, the controller pulls select low and shifts all `NDEV*16` bits MSB first. It then releases select so that every device in the chain loads its new command on the same edge.

All serial timing is set by parameters counted in system-clock cycles: the wait from select falling to the first rising clock, the clock high and low times, the hold from the last rising clock to select rising, and the minimum select-high time before the next frame. Each parameter should be chosen as the smallest cycle count that meets the analog minimum. A per-device sleep mask replaces a device's command with the sleep command (address `1110`) on every frame, so a parked device stays asleep while the others are updated. A separate request pulses an active-low clear line for a programmable width.

Back-pressure rules: `s_ready` is high only while the controller is collecting words, no frame is in progress, and no clear is being requested or driven. A word transfers on a clock edge where both `s_valid` and `s_ready` are high. The source must hold `s_data` stable while `s_valid` is high and `s_ready` is low. The first accepted word of a frame is shifted first, so it lands in the device farthest from the host. The last word lands in the device nearest the host (device index 0).

Top module: `dac_chain_ser`

## Requirements
- R1: After reset, `dac_csn` is 1, `dac_sck` is 0, `dac_clr_n` is 1, `busy` is 0 and `s_ready` is 1.
- R2: While `dac_csn` is low, `dac_sck` rises exactly `NDEV*16` times.
- R3: The bits are sent in acceptance order. The first accepted word goes first, and each word goes MSB first. With a zero sleep mask, the `NDEV*16` bits captured on rising clock edges equal the accepted words concatenated in acceptance order.
- R4: `dac_sck` is already low in the cycle where `dac_csn` falls, and it stays low for at least `T_SETUP` cycles before its first rise.
- R5: Each clock high phase lasts at least `T_HI` cycles, and each low phase between rises lasts at least `T_LO` cycles. `dac_din` does not change while `dac_sck` is high.
- R6: After the last rising clock, `dac_sck` stays low and `dac_csn` stays low for at least `T_HOLD` cycles. Between frames, `dac_csn` stays high for at least `T_CSHI` cycles.
- R7: `busy` is high in every cycle where `dac_csn` is low. After `dac_csn` rises, `busy` stays high for exactly `T_CSHI` more cycles. `s_ready` is 0 whenever `busy` is 1. A frame starts only after the `NDEV`-th word is accepted.
- R8: The k-th accepted word of a frame (k from 0) targets device `NDEV-1-k`. If `sleep_mask[NDEV-1-k]` is 1 when that word is accepted, the word is replaced by 16'hE000 (address field, bits 15:12, = 1110, all other bits 0).
- R9: A `clr_req` sampled high while collecting drives `dac_clr_n` low for exactly `T_CLR` cycles. `s_ready` is 0 during that time. Words already accepted for the current frame are kept.
- R10: A `clr_req` sampled while a frame or its recovery time is in progress is ignored, and `dac_clr_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Command word valid |
| s_ready | output | 1 | Controller can accept a word |
| s_data | input | 16 | Command word (address in bits 15:12) |
| sleep_mask | input | NDEV | Bit i forces sleep on device i (0 = nearest to host) |
| clr_req | input | 1 | Request a clear pulse |
| busy | output | 1 | Frame or select-high recovery in progress |
| dac_sck | output | 1 | Serial clock to the chain |
| dac_din | output | 1 | Serial data to the first device |
| dac_csn | output | 1 | Active-low select/load |
| dac_clr_n | output | 1 | Active-low clear to the chain |

## Verification
The hardest cases to reach are the ones where the serial engine and the stream interface interact. One is a frame that was partly collected, then interrupted by a clear, and then completed. Another is a new frame offered while the previous one is still in its select-high recovery time. The stimulus sends one word, pulses a clear, and then sends the rest, expecting an intact frame afterwards. It also queues words immediately after a frame, so the driver stalls on `s_ready` through recovery, and the measured select-high width and the busy tail are then checked. A clear request issued in the middle of a frame is used to show that the request is dropped.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT, ST_CLEAR, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD, ST_RECOVER
  } dcs_state_e;

  localparam logic [3:0] SLEEP_ADDR = 4'b1110;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dcs_word_buf.sv
module dcs_word_buf #(
  parameter int NDEV   = 3,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              sleep_sel,
  input  logic              shift,
  output logic              ser_bit
);
  localparam int TOT = NDEV * WORD_W;
  localparam logic [WORD_W-1:0] SLEEP_WORD = {dcs_pkg::SLEEP_ADDR, {(WORD_W-4){1'b0}}};

  logic [TOT-1:0]    sr;
  logic [WORD_W-1:0] word_eff;

  assign word_eff = sleep_sel ? SLEEP_WORD : word_in;
  assign ser_bit  = sr[TOT-1];

  generate
    if (NDEV == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= word_eff;
        else if (shift) sr <= {sr[TOT-2:0], 1'b0};
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= {sr[TOT-WORD_W-1:0], word_eff};
        else if (shift) sr <= {sr[TOT-2:0], 1'b0};
      end
    end
  endgenerate
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int NDEV    = 3,
  parameter int NBITS   = 48,
  parameter int IW      = 2,
  parameter int T_SETUP = 3,
  parameter int T_HI    = 2,
  parameter int T_LO    = 2,
  parameter int T_HOLD  = 2,
  parameter int T_CSHI  = 3,
  parameter int T_CLR   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          clr_req,
  output logic          s_ready,
  output logic          load,
  output logic          shift,
  output logic [IW-1:0] widx,
  output logic          sck,
  output logic          csn,
  output logic          busy,
  output logic          clr_n
);
  localparam int TMAX = imax(imax(imax(T_SETUP, T_HI), imax(T_LO, T_HOLD)),
                             imax(imax(T_CSHI, T_CLR), 1));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(NBITS + 1);

  dcs_state_e    state, state_n;
  logic [TW-1:0] tmr, tmr_n;
  logic [BW-1:0] bits, bits_n;
  logic [IW-1:0] widx_n;
  logic          accept;

  assign s_ready = (state == ST_COLLECT) && !clr_req;
  assign accept  = s_valid && s_ready;
  assign load    = accept;
  assign shift   = (state == ST_HIGH) && (tmr == '0) && (bits != BW'(NBITS - 1));

  always_comb begin
    state_n = state;
    tmr_n   = tmr;
    bits_n  = bits;
    widx_n  = widx;
    case (state)
      ST_COLLECT: begin
        if (clr_req) begin
          state_n = ST_CLEAR;
          tmr_n   = TW'(T_CLR - 1);
        end else if (accept) begin
          if (widx == IW'(NDEV - 1)) begin
            widx_n  = '0;
            state_n = ST_SETUP;
            tmr_n   = TW'(T_SETUP - 1);
          end else begin
            widx_n = widx + 1'b1;
          end
        end
      end
      default: begin
        if (tmr != '0) begin
          tmr_n = tmr - 1'b1;
        end else begin
          case (state)
            ST_CLEAR: state_n = ST_COLLECT;
            ST_SETUP: begin
              state_n = ST_HIGH;
              tmr_n   = TW'(T_HI - 1);
              bits_n  = '0;
            end
            ST_HIGH: begin
              if (bits == BW'(NBITS - 1)) begin
                state_n = ST_HOLD;
                tmr_n   = TW'(T_HOLD - 1);
              end else begin
                state_n = ST_LOW;
                tmr_n   = TW'(T_LO - 1);
                bits_n  = bits + 1'b1;
              end
            end
            ST_LOW: begin
              state_n = ST_HIGH;
              tmr_n   = TW'(T_HI - 1);
            end
            ST_HOLD: begin
              state_n = ST_RECOVER;
              tmr_n   = TW'(T_CSHI - 1);
            end
            default: state_n = ST_COLLECT;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      tmr   <= '0;
      bits  <= '0;
      widx  <= '0;
      sck   <= 1'b0;
      csn   <= 1'b1;
      busy  <= 1'b0;
      clr_n <= 1'b1;
    end else begin
      state <= state_n;
      tmr   <= tmr_n;
      bits  <= bits_n;
      widx  <= widx_n;
      sck   <= (state_n == ST_HIGH);
      csn   <= !((state_n == ST_SETUP) || (state_n == ST_HIGH) ||
                 (state_n == ST_LOW)   || (state_n == ST_HOLD));
      busy  <= (state_n != ST_COLLECT) && (state_n != ST_CLEAR);
      clr_n <= (state_n != ST_CLEAR);
    end
  end
endmodule

// File: rtl/dac_chain_ser.sv
module dac_chain_ser #(
  parameter int NDEV    = 3,
  parameter int WORD_W  = 16,
  parameter int T_SETUP = 3,
  parameter int T_HI    = 2,
  parameter int T_LO    = 2,
  parameter int T_HOLD  = 2,
  parameter int T_CSHI  = 3,
  parameter int T_CLR   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic [NDEV-1:0]   sleep_mask,
  input  logic              clr_req,
  output logic              busy,
  output logic              dac_sck,
  output logic              dac_din,
  output logic              dac_csn,
  output logic              dac_clr_n
);
  localparam int NBITS = NDEV * WORD_W;
  localparam int IW    = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic          load, shift, sleep_sel;
  logic [IW-1:0] widx;
  logic [NDEV-1:0] mask_by_order;

  // Word k of a frame travels to device NDEV-1-k.
  for (genvar k = 0; k < NDEV; k++) begin : g_order
    assign mask_by_order[k] = sleep_mask[NDEV-1-k];
  end
  assign sleep_sel = mask_by_order[widx];

  dcs_seq #(
    .NDEV(NDEV), .NBITS(NBITS), .IW(IW),
    .T_SETUP(T_SETUP), .T_HI(T_HI), .T_LO(T_LO),
    .T_HOLD(T_HOLD), .T_CSHI(T_CSHI), .T_CLR(T_CLR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .clr_req(clr_req),
    .s_ready(s_ready), .load(load), .shift(shift), .widx(widx),
    .sck(dac_sck), .csn(dac_csn), .busy(busy), .clr_n(dac_clr_n)
  );

  dcs_word_buf #(.NDEV(NDEV), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(s_data),
    .sleep_sel(sleep_sel), .shift(shift), .ser_bit(dac_din)
  );
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int NBITS = 48
) (
  input logic clk,
  input logic rst_n,
  input logic dac_csn,
  input logic dac_sck,
  input logic dac_din,
  input logic busy,
  input logic s_ready,
  input logic dac_clr_n
);
  localparam int CW = $clog2(NBITS + 2);
  logic [CW-1:0] rises;
  logic          sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rises <= '0;
      sck_q <= 1'b0;
    end else begin
      sck_q <= dac_sck;
      if (dac_csn)                      rises <= '0;
      else if (dac_sck && !sck_q)       rises <= rises + 1'b1;
    end
  end

  assert_sck_low_at_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_csn) |-> !dac_sck);
  assert_bit_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_csn) |-> (rises == CW'(NBITS)));
  assert_din_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sck && $past(dac_sck)) |-> $stable(dac_din));
  assert_sck_inside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sck |-> !dac_csn);
  assert_no_rise_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_csn) |-> !$past(dac_sck));
  assert_busy_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_csn |-> busy);
  assert_no_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);
  assert_clear_outside_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_csn && !busy && !s_ready));
endmodule

bind dac_chain_ser dcs_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_csn(dac_csn), .dac_sck(dac_sck),
  .dac_din(dac_din), .busy(busy), .s_ready(s_ready), .dac_clr_n(dac_clr_n)
);

// File: tb/dac_chain_ser_tb.sv
module dac_chain_ser_tb;
  localparam int NDEV = 3, WW = 16, NB = NDEV * WW;
  localparam int T_SETUP = 3, T_HI = 2, T_LO = 2, T_HOLD = 2, T_CSHI = 3, T_CLR = 4;
  localparam logic [15:0] SLP = 16'hE000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, clr_req = 1'b0;
  logic [15:0] s_data = '0;
  logic [NDEV-1:0] sleep_mask = '0;
  logic s_ready, busy, dac_sck, dac_din, dac_csn, dac_clr_n;

  always #2 clk = ~clk;

  dac_chain_ser #(.NDEV(NDEV), .WORD_W(WW), .T_SETUP(T_SETUP), .T_HI(T_HI),
    .T_LO(T_LO), .T_HOLD(T_HOLD), .T_CSHI(T_CSHI), .T_CLR(T_CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sleep_mask(sleep_mask), .clr_req(clr_req), .busy(busy), .dac_sck(dac_sck),
    .dac_din(dac_din), .dac_csn(dac_csn), .dac_clr_n(dac_clr_n));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [NB-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver side of the scoreboard
  task automatic put_word(input logic [15:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_data = '0;
  endtask

  task automatic send_frame(input logic [15:0] w0, w1, w2, input logic [NDEV-1:0] m);
    logic [15:0] e0, e1, e2;
    e0 = m[2] ? SLP : w0;  // word 0 -> device 2 (R8)
    e1 = m[1] ? SLP : w1;
    e2 = m[0] ? SLP : w2;
    exp_q.push_back({e0, e1, e2});
    sleep_mask = m;
    put_word(w0); put_word(w1); put_word(w2);
  endtask

  // monitor: models the chain and measures serial timing
  logic p_csn = 1'b1, p_sck = 1'b0, p_busy = 1'b0, p_din = 1'b0;
  int run = 0, bits = 0, hi_run = 0, rec = 0;
  bit first = 0, seen = 0, busy_bad = 0, ready_bad = 0, din_bad = 0;
  logic [NB-1:0] cap = '0;
  int clr_lo = 0;
  bit clr_ready_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dac_clr_n) begin clr_lo++; if (s_ready) clr_ready_bad = 1; end
      if (!dac_csn && !busy) busy_bad = 1;
      if (busy && s_ready) ready_bad = 1;
      if (p_csn && !dac_csn) begin
        chk(dac_sck == 1'b0, "R4 sck low at select fall", dac_sck, 0);
        if (seen) chk(hi_run >= T_CSHI, "R6 select high width", hi_run, T_CSHI);
        run = 1; first = 1; bits = 0; cap = '0; din_bad = 0;
      end else if (!dac_csn) begin
        if (dac_sck && !p_sck) begin
          if (first) chk(run >= T_SETUP, "R4 select-to-first-rise", run, T_SETUP);
          else       chk(run >= T_LO, "R5 clock low time", run, T_LO);
          first = 0; cap = {cap[NB-2:0], dac_din}; bits++; run = 1;
        end else if (!dac_sck && p_sck) begin
          chk(run >= T_HI, "R5 clock high time", run, T_HI);
          run = 1;
        end else begin
          if (dac_sck && dac_din != p_din) din_bad = 1;
          run++;
        end
      end else if (!p_csn && dac_csn) begin
        logic [NB-1:0] e;
        chk(run >= T_HOLD, "R6 hold after last rise", run, T_HOLD);
        chk(bits == NB, "R2 rising edges per frame", bits, NB);
        chk(!din_bad, "R5 data stable while clock high", din_bad, 0);
        chk(!busy_bad, "R7 busy during select low", busy_bad, 0);
        chk(busy, "R7 busy at select rise", busy, 1);
        if (exp_q.size() == 0) chk(0, "R3 unexpected frame", cap, 0);
        else begin
          e = exp_q.pop_front();
          chk(cap == e, "R3/R8 frame content", cap, e);
        end
        hi_run = 1; rec = 1; seen = 1; busy_bad = 0;
      end else begin
        hi_run++;
        if (busy) rec++;
        else if (p_busy && seen) begin
          chk(rec == T_CSHI, "R7 busy tail after select rise", rec, T_CSHI);
          chk(!ready_bad, "R7 ready low while busy", ready_bad, 0);
          ready_bad = 0;
        end
      end
      p_csn = dac_csn; p_sck = dac_sck; p_busy = busy; p_din = dac_din;
    end
  end

  task automatic pulse_clr();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_csn == 1 && dac_sck == 0 && dac_clr_n == 1, "R1 serial pins after reset",
        {dac_csn, dac_sck, dac_clr_n}, 3'b101);
    chk(busy == 0 && s_ready == 1, "R1 busy/ready after reset", {busy, s_ready}, 2'b01);

    // R3: plain frame, zero mask
    send_frame(16'h1A5C, 16'h2F03, 16'h8FFF, 3'b000);
    // queued immediately: driver stalls through recovery (R7, R6)
    send_frame(16'h0001, 16'hFFFF, 16'h7E81, 3'b000);
    wait_idle();

    // R8: nearest device parked, then two farthest
    send_frame(16'h1234, 16'h5678, 16'h9ABC, 3'b001);
    send_frame(16'h4321, 16'h8765, 16'h0FED, 3'b110);
    wait_idle();

    // R9: clear in idle, exact width, ready low
    clr_lo = 0; clr_ready_bad = 0;
    pulse_clr();
    repeat (12) @(negedge clk);
    chk(clr_lo == T_CLR, "R9 clear pulse width", clr_lo, T_CLR);
    chk(!clr_ready_bad, "R9 ready low during clear", clr_ready_bad, 0);

    // R9: clear between words keeps the partial frame
    exp_q.push_back({16'hA001, 16'hB002, 16'hC003});
    sleep_mask = '0;
    put_word(16'hA001);
    clr_lo = 0;
    pulse_clr();
    repeat (8) @(negedge clk);
    chk(clr_lo == T_CLR, "R9 clear width with partial frame", clr_lo, T_CLR);
    put_word(16'hB002); put_word(16'hC003);
    wait_idle();

    // R10: clear requested mid-frame is dropped
    send_frame(16'h3C3C, 16'hC3C3, 16'h5555, 3'b000);
    while (dac_csn) @(negedge clk);
    repeat (5) @(negedge clk);
    clr_lo = 0;
    pulse_clr();
    wait_idle();
    chk(clr_lo == 0, "R10 clear ignored while busy", clr_lo, 0);

    // R7: idle with words outstanding keeps select high
    sleep_mask = '0;
    exp_q.push_back({16'hDEAD, 16'hBEEF, 16'h0F0F});
    put_word(16'hDEAD); put_word(16'hBEEF);
    repeat (6) @(negedge clk);
    chk(dac_csn == 1 && busy == 0, "R7 no frame before last word", {dac_csn, busy}, 2'b10);
    put_word(16'h0F0F);
    wait_idle();
    chk(exp_q.size() == 0, "R2 all frames observed", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule